// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations and searches all of them in parallel. Every entry is tagged by virtual page number, partition number, context number and a real-mode flag, and carries a physical page number and a lock flag. One request is accepted per cycle on a single request port: a lookup, an insert, or one of three invalidations (by page, by context, or a whole partition). All results appear on registered outputs one cycle after the request.

Inserts go either to an index given with the request or to a victim chosen by the block. The victim choice uses one "recently used" flag per entry. Lookup hits set that flag. The flags are reset whenever an insert would leave all of them set. A one-entry shortcut register keeps the most recent lookup hit. Every insert and every invalidation clears it, so it can never return a translation that has been removed.

Top module: `tagged_xlate_buf`

## Requirements
- R1: While `rst` is high, every entry becomes invalid and the shortcut is cleared. In the cycle after reset, all response outputs are low and a lookup of any tag misses.
- R2: A lookup (`req_op` = 0) hits only on a valid entry whose page, partition, context and real flag all equal the request. One cycle later, `rsp_valid` is high together with exactly one of `rsp_hit` and `rsp_miss`. On a hit, `rsp_ppn` and `rsp_idx` show that entry. A miss changes no state.
- R3: A lookup hit sets the used flag of the matched entry.
- R4: An insert (`req_op` = 1) with `ins_at_idx` high writes entry `ins_idx`. Without it, the insert writes the lowest-indexed invalid entry, or failing that the lowest-indexed entry with a clear used flag. One cycle later, `ins_done` pulses and `rsp_idx` shows the written index.
- R5: Before an insert writes, any valid entry with the same four-field tag is invalidated and its used flag cleared. No two valid entries ever share a tag.
- R6: The inserted entry's used flag is set. If that leaves every used flag set, all others are cleared.
- R7: Demap page (`req_op` = 2) invalidates the valid entry whose four-field tag equals the request and clears its used flag.
- R8: Demap context (`req_op` = 3) invalidates every entry whose partition and context both match, regardless of page, real flag or lock.
- R9: Demap all (`req_op` = 4) invalidates every entry of the requested partition unless its lock flag is set. Entries of other partitions are untouched.
- R10: Every demap raises `demap_done` for exactly the following cycle, produces no lookup response, and clears the shortcut so a later lookup of a removed page misses.
- R11: Operation codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 lookup, 1 insert, 2 demap page, 3 demap context, 4 demap all |
| req_vpn | input | VPN_W | Virtual page number |
| req_part | input | PART_W | Partition number |
| req_ctx | input | CTX_W | Context number |
| req_real | input | 1 | Real-mode flag of the tag |
| ins_ppn | input | PPN_W | Physical page for an insert |
| ins_lock | input | 1 | Lock flag for an insert |
| ins_at_idx | input | 1 | Insert at `ins_idx` instead of the chosen victim |
| ins_idx | input | IDX_W | Explicit insert index |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_ppn | output | PPN_W | Physical page on a hit |
| rsp_idx | output | IDX_W | Hit index, or index written by an insert |
| ins_done | output | 1 | Insert completed |
| demap_done | output | 1 | Demap completed |

## Verification
The embedded properties watch, on every cycle, the response timing of lookups, inserts and demaps. They also check that explicit-index inserts land where asked, that tags stay unique, that the newly written entry keeps its used flag, and that locked entries survive a partition-wide demap. Which victim the block picks, whether hits really set used flags, and whether conflict and context invalidation remove the right entries can only be shown by the bench's sequences. Those sequences fill the buffer, age it with lookups, and then observe where later inserts land and which lookups still hit.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP   = 3'd0,
    OP_INSERT   = 3'd1,
    OP_DMP_PAGE = 3'd2,
    OP_DMP_CTX  = 3'd3,
    OP_DMP_ALL  = 3'd4
  } xlb_op_e;
endpackage

// File: rtl/xlb_pick.sv
// Lowest-index priority picker over a request vector.
module xlb_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlb_tag_cmp.sv
// Parallel tag comparison across all entries.
module xlb_tag_cmp #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PART_W = 3,
  parameter int CTX_W  = 8
) (
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][PART_W-1:0] ent_part,
  input  logic [N-1:0][CTX_W-1:0]  ent_ctx,
  input  logic [N-1:0]             ent_real,
  input  logic [N-1:0]             ent_valid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [PART_W-1:0]        key_part,
  input  logic [CTX_W-1:0]         key_ctx,
  input  logic                     key_real,
  output logic [N-1:0]             page_hit,
  output logic [N-1:0]             ctx_hit,
  output logic [N-1:0]             part_hit
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic p_eq, c_eq, v_eq;
    assign p_eq        = (ent_part[g] == key_part);
    assign c_eq        = (ent_ctx[g] == key_ctx);
    assign v_eq        = (ent_vpn[g] == key_vpn) && (ent_real[g] == key_real);
    assign part_hit[g] = ent_valid[g] && p_eq;
    assign ctx_hit[g]  = ent_valid[g] && p_eq && c_eq;
    assign page_hit[g] = ent_valid[g] && p_eq && c_eq && v_eq;
  end
endmodule

// File: rtl/tagged_xlate_buf.sv
module tagged_xlate_buf
  import xlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PART_W  = 3,
  parameter int CTX_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PART_W-1:0] req_part,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_real,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic              ins_lock,
  input  logic              ins_at_idx,
  input  logic [IDX_W-1:0]  ins_idx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              ins_done,
  output logic              demap_done
);
  localparam int N = ENTRIES;

  // Entry payload: no reset, written one index at a time.
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][PART_W-1:0] part_q;
  logic [N-1:0][CTX_W-1:0]  ctx_q;
  logic [N-1:0]             real_q;
  logic [N-1:0]             lock_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  // Control state with reset.
  logic [N-1:0] valid_q, used_q, valid_n, used_n;

  // Shortcut register: most recent lookup hit.
  logic              sc_valid_q;
  logic [VPN_W-1:0]  sc_vpn_q;
  logic [PART_W-1:0] sc_part_q;
  logic [CTX_W-1:0]  sc_ctx_q;
  logic              sc_real_q;
  logic [IDX_W-1:0]  sc_idx_q;

  xlb_op_e op;
  logic do_look, do_ins, do_dpage, do_dctx, do_dall, do_dmp;

  assign op       = xlb_op_e'(req_op);
  assign do_look  = req_valid && (op == OP_LOOKUP);
  assign do_ins   = req_valid && (op == OP_INSERT);
  assign do_dpage = req_valid && (op == OP_DMP_PAGE);
  assign do_dctx  = req_valid && (op == OP_DMP_CTX);
  assign do_dall  = req_valid && (op == OP_DMP_ALL);
  assign do_dmp   = do_dpage || do_dctx || do_dall;

  logic [N-1:0] page_hit, ctx_hit, part_hit;

  xlb_tag_cmp #(.N(N), .VPN_W(VPN_W), .PART_W(PART_W), .CTX_W(CTX_W)) u_cmp (
    .ent_vpn  (vpn_q),
    .ent_part (part_q),
    .ent_ctx  (ctx_q),
    .ent_real (real_q),
    .ent_valid(valid_q),
    .key_vpn  (req_vpn),
    .key_part (req_part),
    .key_ctx  (req_ctx),
    .key_real (req_real),
    .page_hit (page_hit),
    .ctx_hit  (ctx_hit),
    .part_hit (part_hit)
  );

  logic             arr_any, inv_any, free_any;
  logic [IDX_W-1:0] arr_idx, inv_idx, free_idx;

  xlb_pick #(.N(N)) u_pick_hit (.vec(page_hit), .any(arr_any), .idx(arr_idx));
  // Conflicting entries count as free for the victim choice.
  xlb_pick #(.N(N)) u_pick_inv (.vec(~valid_q | page_hit), .any(inv_any), .idx(inv_idx));
  xlb_pick #(.N(N)) u_pick_free (.vec(~used_q), .any(free_any), .idx(free_idx));

  logic             sc_hit, look_hit;
  logic [IDX_W-1:0] look_idx, vic_idx;

  assign sc_hit   = sc_valid_q && (sc_vpn_q == req_vpn) && (sc_part_q == req_part) &&
                    (sc_ctx_q == req_ctx) && (sc_real_q == req_real);
  assign look_hit = sc_hit || arr_any;
  assign look_idx = sc_hit ? sc_idx_q : arr_idx;

  always_comb begin
    if (ins_at_idx)    vic_idx = ins_idx;
    else if (inv_any)  vic_idx = inv_idx;
    else if (free_any) vic_idx = free_idx;
    else               vic_idx = '0;
  end

  // Next valid / used state.
  always_comb begin
    valid_n = valid_q;
    used_n  = used_q;
    if (do_look && look_hit) begin
      used_n[look_idx] = 1'b1;
    end
    if (do_ins) begin
      valid_n = valid_n & ~page_hit;
      used_n  = used_n & ~page_hit;
      valid_n[vic_idx] = 1'b1;
      used_n[vic_idx]  = 1'b1;
      if (&used_n) begin
        used_n = '0;
        used_n[vic_idx] = 1'b1;
      end
    end
    if (do_dpage) begin
      valid_n = valid_n & ~page_hit;
      used_n  = used_n & ~page_hit;
    end
    if (do_dctx) begin
      valid_n = valid_n & ~ctx_hit;
      used_n  = used_n & ~ctx_hit;
    end
    if (do_dall) begin
      valid_n = valid_n & ~(part_hit & ~lock_q);
      used_n  = used_n & ~(part_hit & ~lock_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      valid_q <= valid_n;
      used_q  <= used_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      vpn_q[vic_idx]  <= req_vpn;
      part_q[vic_idx] <= req_part;
      ctx_q[vic_idx]  <= req_ctx;
      real_q[vic_idx] <= req_real;
      lock_q[vic_idx] <= ins_lock;
      ppn_q[vic_idx]  <= ins_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid_q <= 1'b0;
      sc_vpn_q   <= '0;
      sc_part_q  <= '0;
      sc_ctx_q   <= '0;
      sc_real_q  <= 1'b0;
      sc_idx_q   <= '0;
    end else if (do_ins || do_dmp) begin
      sc_valid_q <= 1'b0;
    end else if (do_look && !sc_hit && arr_any) begin
      sc_valid_q <= 1'b1;
      sc_vpn_q   <= req_vpn;
      sc_part_q  <= req_part;
      sc_ctx_q   <= req_ctx;
      sc_real_q  <= req_real;
      sc_idx_q   <= arr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_ppn    <= '0;
      rsp_idx    <= '0;
      ins_done   <= 1'b0;
      demap_done <= 1'b0;
    end else begin
      rsp_valid  <= do_look;
      rsp_hit    <= do_look && look_hit;
      rsp_miss   <= do_look && !look_hit;
      rsp_ppn    <= (do_look && look_hit) ? ppn_q[look_idx] : '0;
      rsp_idx    <= do_look ? (look_hit ? look_idx : '0) : (do_ins ? vic_idx : '0);
      ins_done   <= do_ins;
      demap_done <= do_dmp;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (valid_q == '0) && !sc_valid_q);
  // R2
  look_resp_chk: assert property (@(posedge clk) disable iff (rst)
    do_look |=> rsp_valid && (rsp_hit != rsp_miss) && !ins_done && !demap_done);
  // R4
  ins_at_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (do_ins && ins_at_idx) |=> ins_done && (rsp_idx == $past(ins_idx)));
  // R5
  tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(page_hit));
  // R6
  new_used_chk: assert property (@(posedge clk) disable iff (rst)
    ins_done |-> used_q[rsp_idx] && valid_q[rsp_idx]);
  // R9
  lock_keep_chk: assert property (@(posedge clk) disable iff (rst)
    do_dall |=> (($past(valid_q & lock_q) & ~valid_q) == '0));
  // R10
  demap_done_chk: assert property (@(posedge clk) disable iff (rst)
    do_dmp |=> demap_done && !rsp_valid && !sc_valid_q);
endmodule

// File: tb/tagged_xlate_buf_tb.sv
module tagged_xlate_buf_tb;
  localparam int N = 4;
  localparam int IW = 2;
  localparam int P1 = 1;
  localparam int P2 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [19:0] req_vpn = '0;
  logic [2:0] req_part = '0;
  logic [7:0] req_ctx = '0;
  logic req_real = 1'b0;
  logic [19:0] ins_ppn = '0;
  logic ins_lock = 1'b0;
  logic ins_at_idx = 1'b0;
  logic [IW-1:0] ins_idx = '0;
  logic rsp_valid, rsp_hit, rsp_miss, ins_done, demap_done;
  logic [19:0] rsp_ppn;
  logic [IW-1:0] rsp_idx;

  always #4 clk = ~clk;

  tagged_xlate_buf #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_vpn(req_vpn), .req_part(req_part), .req_ctx(req_ctx), .req_real(req_real),
    .ins_ppn(ins_ppn), .ins_lock(ins_lock), .ins_at_idx(ins_at_idx), .ins_idx(ins_idx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_ppn(rsp_ppn),
    .rsp_idx(rsp_idx), .ins_done(ins_done), .demap_done(demap_done)
  );

  typedef struct {
    int          kind;   // 0 lookup, 1 insert, 2 demap, 3 nothing
    bit          hit;
    logic [19:0] ppn;
    int          idx;
    string       rq;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  task automatic fail(string rq, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
  endtask

  // Monitor: compare each response against the scoreboard head.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (running && q.size() > 0) begin
        exp_t e;
        int kind;
        e = q.pop_front();
        kind = rsp_valid ? 0 : ins_done ? 1 : demap_done ? 2 : 3;
        checks++;
        if (kind != e.kind) fail(e.rq, "kind", kind, e.kind);
        else if (kind == 0) begin
          if (rsp_hit != e.hit || rsp_miss == e.hit) fail(e.rq, "hit", rsp_hit, e.hit);
          else if (e.hit && (rsp_ppn != e.ppn || rsp_idx != e.idx))
            fail(e.rq, "ppn/idx", {rsp_ppn, 2'(rsp_idx)}, {e.ppn, 2'(e.idx)});
        end else if (kind == 1 && rsp_idx != e.idx) fail(e.rq, "idx", rsp_idx, e.idx);
      end
    end
  end

  task automatic push(int kind, bit hit, logic [19:0] ppn, int idx, string rq);
    exp_t e;
    e.kind = kind; e.hit = hit; e.ppn = ppn; e.idx = idx; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic look(int vpn, int part, int ctx, bit rl, bit hit, int idx, int ppn, string rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_vpn = 20'(vpn); req_part = 3'(part);
    req_ctx = 8'(ctx); req_real = rl;
    push(0, hit, 20'(ppn), idx, rq);
  endtask

  task automatic ins(int vpn, int part, int ctx, int ppn, bit lk, bit at, int idx, int exp_idx, string rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_vpn = 20'(vpn); req_part = 3'(part);
    req_ctx = 8'(ctx); req_real = 1'b0; ins_ppn = 20'(ppn); ins_lock = lk;
    ins_at_idx = at; ins_idx = IW'(idx);
    push(1, 1'b0, '0, exp_idx, rq);
  endtask

  task automatic dmp(int op, int vpn, int part, int ctx, string rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_vpn = 20'(vpn); req_part = 3'(part);
    req_ctx = 8'(ctx); req_real = 1'b0;
    push(op >= 5 ? 3 : 2, 1'b0, '0, 0, rq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset state of outputs
    if (rsp_valid || rsp_hit || rsp_miss || ins_done || demap_done)
      fail("R1", "outputs after reset", {rsp_valid, rsp_hit, rsp_miss, ins_done, demap_done}, 0);
    running = 1'b1;
    look(16'h10, P1, 5, 0, 0, 0, 0, "R1 empty lookup");
    ins(16'h10, P1, 5, 16'h5010, 0, 0, 0, 0, "R4 first invalid");
    ins(16'h11, P1, 5, 16'h5011, 0, 0, 0, 1, "R4 next invalid");
    ins(16'h12, P1, 5, 16'h5012, 0, 0, 0, 2, "R4 next invalid");
    look(16'h11, P1, 5, 0, 1, 1, 16'h5011, "R2 hit");
    look(16'h10, P1, 5, 1, 0, 0, 0, "R2 real flag differs");
    look(16'h10, P1, 6, 0, 0, 0, 0, "R2 context differs");
    look(16'h10, P2, 5, 0, 0, 0, 0, "R2 partition differs");
    dmp(5, 16'h10, P1, 5, "R11 code 5 ignored");
    look(16'h10, P1, 5, 0, 1, 0, 16'h5010, "R11 entry kept");
    ins(16'h13, P1, 5, 16'h5013, 0, 0, 0, 3, "R4 last invalid");
    ins(16'h20, P1, 5, 16'h5020, 0, 0, 0, 0, "R6 used reset then lowest clear");
    look(16'h10, P1, 5, 0, 0, 0, 0, "R4 evicted entry");
    look(16'h11, P1, 5, 0, 1, 1, 16'h5011, "R3 hit marks used");
    ins(16'h21, P1, 5, 16'h5021, 0, 0, 0, 2, "R3 used entry skipped");
    ins(16'h11, P1, 5, 16'h7011, 0, 1, 3, 3, "R4 explicit index");
    look(16'h11, P1, 5, 0, 1, 3, 16'h7011, "R5 new copy");
    look(16'h13, P1, 5, 0, 0, 0, 0, "R4 overwritten");
    ins(16'h30, P1, 5, 16'h5030, 1, 0, 0, 1, "R5 conflict slot freed");
    look(16'h21, P1, 5, 0, 1, 2, 16'h5021, "R2 hit");
    look(16'h21, P1, 5, 0, 1, 2, 16'h5021, "R10 shortcut hit");
    dmp(2, 16'h21, P1, 5, "R7 demap page");
    look(16'h21, P1, 5, 0, 0, 0, 0, "R10 shortcut cleared");
    dmp(2, 16'h20, P1, 6, "R7 wrong context");
    look(16'h20, P1, 5, 0, 1, 0, 16'h5020, "R7 untouched");
    ins(16'h40, P1, 7, 16'h5040, 0, 1, 2, 2, "R4 explicit index");
    dmp(3, 16'h0, P1, 5, "R8 demap context");
    look(16'h40, P1, 7, 0, 1, 2, 16'h5040, "R8 other context kept");
    look(16'h20, P1, 5, 0, 0, 0, 0, "R8 removed");
    look(16'h30, P1, 5, 0, 0, 0, 0, "R8 locked removed");
    look(16'h11, P1, 5, 0, 0, 0, 0, "R8 removed");
    ins(16'h50, P1, 5, 16'h5050, 1, 0, 0, 0, "R4 lowest invalid");
    ins(16'h51, P2, 5, 16'h5051, 0, 0, 0, 1, "R4 lowest invalid");
    dmp(4, 16'h0, P1, 0, "R9 demap all");
    look(16'h50, P1, 5, 0, 1, 0, 16'h5050, "R9 locked spared");
    look(16'h40, P1, 7, 0, 0, 0, 0, "R9 unlocked removed");
    look(16'h51, P2, 5, 0, 1, 1, 16'h5051, "R9 other partition kept");
    ins(16'h60, P1, 5, 16'h5060, 0, 0, 0, 2, "R9 freed slot reused");
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      fail("R2", "missing responses", q.size(), 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule